// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands in a single combinational pass. Every partial-product bit is formed at once by an AND gate. The partial-product rows are then taken in groups of four and summed by rows of (4,2) counters. Each counter is made of two full adders. It takes four bits of one weight plus a lateral carry from its lower neighbour. It returns one sum bit and two carries of the next weight, so each counter row turns four rows into two.

With the default 8-bit operands, two first-level counter rows turn the eight partial-product rows into four. A second-level row turns those four into two. A single carry-propagate adder then forms the 16-bit product. A 4-bit configuration needs only the first level. A parameter chooses the final adder: a ripple adder, or a log-depth parallel-prefix adder.

The block has no clock and no state. The product follows the operands through combinational logic only.

Top module: `c42_mult`

## Requirements
- R1: With WIDTH=8 and the prefix final adder (CPA_KIND=1, the default), product equals mcand × mplier for every one of the 65536 operand pairs, as a 16-bit unsigned value.
- R2: The counter cell obeys sum + 2·(carry + cout) = a + b + c + d + cin for all 32 input combinations.
- R3: The counter cell's lateral carry output cout does not depend on its carry input cin, for every value of a, b, c and d.
- R4: A counter row of N cells, whose lowest cell has carry input 0 and whose lateral carries pass upward, gives sum + 2·carry + 2^N·cout = a + b + c + d for its four N-bit inputs.
- R5: A zero operand gives a zero product. The largest operands (255 × 255) give 0xFE01.
- R6: The second reduction level sends no carry past bit 2·WIDTH−1, so a 2·WIDTH-bit final adder is exact even at the largest operands.
- R7: With the ripple final adder (CPA_KIND=0), product is identical to the R1 result for every operand pair.
- R8: With WIDTH=4, a single reduction level and an 8-bit final adder give product = mcand × mplier for all 256 operand pairs.
- R9: The product settles from the operands alone, with no clock edge. It is valid one settling interval after the operands change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH (8) | Unsigned multiplicand |
| mplier | input | WIDTH (8) | Unsigned multiplier; bit r selects partial-product row r |
| product | output | 2·WIDTH (16) | Unsigned product |

## Verification
The 8-bit multiplier is swept over every operand pair, with both adder variants side by side. A wrong product then shows whether the fault lies in the shared reduction tree (both variants fail) or in one final adder (only one fails). Zero and full-scale operands are singled out: they separate a stuck partial-product bit from a carry lost at the top column.

The counter cell is tried over its full truth table, with carry-in toggled for each fixed set of data inputs. This exposes a lateral carry that wrongly depends on carry-in. A standalone counter row is driven with all-zero, all-one, alternating and scrambled words. These show whether the lateral carry chain joins the cells in the right order. The 4-bit configuration is swept in full to cover the single-level variant.

// File: rtl/c42_pkg.sv
package c42_pkg;
   // Final carry-propagate adder variants
   localparam int CPA_RIPPLE = 0;
   localparam int CPA_PREFIX = 1;
   // Number of same-weight data inputs of one counter
   localparam int CNT_FANIN  = 4;
endpackage

// File: rtl/c42_fa.sv
module c42_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   assign s  = a ^ b ^ ci;
   assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/c42_cell.sv
// (4,2) counter: two cascaded full adders. cout is taken from the first
// adder only, so it never waits on cin.
module c42_cell (
   input  logic a,
   input  logic b,
   input  logic c,
   input  logic d,
   input  logic cin,
   output logic sum,
   output logic carry,
   output logic cout
);
   logic mid;

   c42_fa u_fa_hi (.a(a),   .b(b), .ci(c),   .s(mid), .co(cout));
   c42_fa u_fa_lo (.a(mid), .b(d), .ci(cin), .s(sum), .co(carry));
endmodule

// File: rtl/c42_row.sv
// One row of N counters sharing a lateral carry chain from bit 0 upward.
module c42_row #(
   parameter int N = 8
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic [N-1:0] c,
   input  logic [N-1:0] d,
   output logic [N-1:0] sum,
   output logic [N-1:0] carry,
   output logic         cout
);
   if (N < 1) begin : g_bad_n
      $error("c42_row: N must be at least 1");
   end

   logic [N:0] lat;
   assign lat[0] = 1'b0;

   for (genvar k = 0; k < N; k++) begin : g_cell
      c42_cell u_cell (
         .a(a[k]), .b(b[k]), .c(c[k]), .d(d[k]), .cin(lat[k]),
         .sum(sum[k]), .carry(carry[k]), .cout(lat[k+1])
      );
   end

   assign cout = lat[N];
endmodule

// File: rtl/c42_cpa.sv
// Final carry-propagate adder, result taken modulo 2^N.
module c42_cpa
   import c42_pkg::*;
#(
   parameter int N    = 16,
   parameter int KIND = CPA_PREFIX
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   output logic [N-1:0] s
);
   if (N < 3) begin : g_bad_n
      $error("c42_cpa: N must be at least 3");
   end
   if (KIND != CPA_RIPPLE && KIND != CPA_PREFIX) begin : g_bad_kind
      $error("c42_cpa: unknown adder kind");
   end

   if (KIND == CPA_RIPPLE) begin : g_ripple
      logic [N-1:0] ch;
      assign ch[0] = 1'b0;
      for (genvar i = 0; i < N - 1; i++) begin : g_bit
         c42_fa u_fa (.a(x[i]), .b(y[i]), .ci(ch[i]), .s(s[i]), .co(ch[i+1]));
      end
      assign s[N-1] = x[N-1] ^ y[N-1] ^ ch[N-1];
   end else begin : g_prefix
      localparam int M = N - 1;          // carries into bits 1..N-1
      localparam int L = $clog2(M);      // prefix levels

      logic [N-1:0]      hx;
      logic [L:0][M-1:0] gk;

      assign hx    = x ^ y;
      assign gk[0] = x[M-1:0] & y[M-1:0];

      for (genvar l = 0; l < L; l++) begin : g_lvl
         localparam int D = 1 << l;
         // group propagate, kept only for spans not yet reaching bit 0
         logic [M-1:D] pin;
         if (l == 0) begin : g_p0
            assign pin = hx[M-1:1];
         end else begin : g_pn
            assign pin = g_lvl[l-1].g_nx.pnx;
         end
         for (genvar i = 0; i < M; i++) begin : g_g
            if (i >= D) begin : g_comb
               assign gk[l+1][i] = gk[l][i] | (pin[i] & gk[l][i-D]);
            end else begin : g_pass
               assign gk[l+1][i] = gk[l][i];
            end
         end
         if (2 * D <= M - 1) begin : g_nx
            logic [M-1:2*D] pnx;
            for (genvar i = 2 * D; i < M; i++) begin : g_p
               assign pnx[i] = pin[i] & pin[i-D];
            end
         end
      end

      assign s[0] = hx[0];
      for (genvar i = 1; i < N; i++) begin : g_sum
         assign s[i] = hx[i] ^ gk[L][i-1];
      end
   end
endmodule

// File: rtl/c42_mult.sv
module c42_mult
   import c42_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int CPA_KIND = CPA_PREFIX
) (
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic [2*WIDTH-1:0] product
);
   localparam int P      = 2 * WIDTH;          // product width
   localparam int GROUPS = WIDTH / CNT_FANIN;  // first-level counter rows
   localparam int RW     = WIDTH + CNT_FANIN - 1;  // span of one group
   localparam int OW     = RW + 1;                 // span after reduction

   if (!(WIDTH == 4 || WIDTH == 8)) begin : g_bad_width
      $error("c42_mult: WIDTH must be 4 or 8");
   end

   // Partial products: row r is the multiplicand gated by multiplier bit r
   logic [WIDTH-1:0][WIDTH-1:0] pp;
   for (genvar r = 0; r < WIDTH; r++) begin : g_pp
      assign pp[r] = mcand & {WIDTH{mplier[r]}};
   end

   // First level: each group of four rows becomes a sum and a carry vector
   logic [GROUPS-1:0][P-1:0] ls;
   logic [GROUPS-1:0][P-1:0] lc;

   for (genvar g = 0; g < GROUPS; g++) begin : g_l1
      logic [CNT_FANIN-1:0][RW-1:0] vin;
      logic [RW-1:0] s1;
      logic [RW-1:0] c1;
      logic          co1;

      for (genvar k = 0; k < CNT_FANIN; k++) begin : g_align
         assign vin[k] = RW'(pp[CNT_FANIN*g+k]) << k;
      end

      c42_row #(.N(RW)) u_row (
         .a(vin[0]), .b(vin[1]), .c(vin[2]), .d(vin[3]),
         .sum(s1), .carry(c1), .cout(co1)
      );

      assign ls[g] = P'({co1, s1})  << (CNT_FANIN * g);
      assign lc[g] = P'({c1, 1'b0}) << (CNT_FANIN * g);
   end

   // Second level (two groups) or direct hand-off (one group)
   logic [P-1:0] opx;
   logic [P-1:0] opy;
   logic [1:0]   spill;

   if (GROUPS == 1) begin : g_one_level
      assign opx   = ls[0];
      assign opy   = lc[0];
      assign spill = 2'b00;
   end else begin : g_two_level
      logic [P-1:0] s2;
      logic [P-1:0] c2;
      logic         co2;

      c42_row #(.N(P)) u_row2 (
         .a(ls[0]), .b(lc[0]), .c(ls[GROUPS-1]), .d(lc[GROUPS-1]),
         .sum(s2), .carry(c2), .cout(co2)
      );

      assign opx   = s2;
      assign opy   = {c2[P-2:0], 1'b0};
      assign spill = {co2, c2[P-1]};
   end

   c42_cpa #(.N(P), .KIND(CPA_KIND)) u_cpa (
      .x(opx), .y(opy), .s(product)
   );
endmodule

// File: rtl/c42_mult_chk.sv
module c42_mult_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0]     mcand,
   input logic [WIDTH-1:0]     mplier,
   input logic [2*WIDTH-1:0]   product,
   input logic [WIDTH/2*WIDTH-1:0] lsum_s,
   input logic [WIDTH/2*WIDTH-1:0] lsum_c,
   input logic [2*WIDTH-1:0]   opx,
   input logic [2*WIDTH-1:0]   opy,
   input logic [1:0]           spill
);
   localparam int P      = 2 * WIDTH;
   localparam int GROUPS = WIDTH / 4;

   logic [P-1:0] ref_p;
   logic [P-1:0] acc;
   logic [P-1:0] fin;

   always_comb begin
      ref_p = P'(mcand) * P'(mplier);
      acc   = '0;
      for (int g = 0; g < GROUPS; g++) begin
         acc = acc + lsum_s[g*P +: P] + lsum_c[g*P +: P];
      end
      fin = opx + opy;

      p_prod_r1: assert (product == ref_p)
         else $error("product %0h expected %0h", product, ref_p);
      // first-level vectors together still carry the exact product
      p_level1_r4: assert (acc == ref_p)
         else $error("level-1 vectors sum to %0h expected %0h", acc, ref_p);
      // the adder operands carry the same value as the level-1 vectors
      p_level2_r4: assert (fin == acc)
         else $error("adder operands sum to %0h expected %0h", fin, acc);
      p_no_overflow_r6: assert (spill == 2'b00)
         else $error("carry spilled past the top column: %b", spill);
      p_zero_r5: assert (!(mcand == '0 || mplier == '0) || product == '0)
         else $error("zero operand gave product %0h", product);
      p_cpa_r7: assert (product == fin)
         else $error("final adder gave %0h expected %0h", product, fin);
   end
endmodule

bind c42_mult c42_mult_chk #(.WIDTH(WIDTH)) u_chk (
   .mcand(mcand), .mplier(mplier), .product(product),
   .lsum_s(ls), .lsum_c(lc), .opx(opx), .opy(opy), .spill(spill)
);

// File: tb/tb_c42_mult.sv
`timescale 1ns/1ps
module tb_c42_mult;
   logic clk = 1'b0;
   logic rst;
   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // 8x8, prefix adder, and 8x8 ripple adder sharing the operands
   logic [7:0]  ma, mb;
   logic [15:0] prod_p, prod_r;
   c42_mult #(.WIDTH(8), .CPA_KIND(1)) dut     (.mcand(ma), .mplier(mb), .product(prod_p));
   c42_mult #(.WIDTH(8), .CPA_KIND(0)) dut_rip (.mcand(ma), .mplier(mb), .product(prod_r));

   // 4x4 single-level configuration
   logic [3:0] qa, qb;
   logic [7:0] prod4;
   c42_mult #(.WIDTH(4)) dut4 (.mcand(qa), .mplier(qb), .product(prod4));

   // standalone counter cell
   logic ca, cb, cc, cd, cci, cs, ccy, cco;
   c42_cell u_cell (.a(ca), .b(cb), .c(cc), .d(cd), .cin(cci),
                    .sum(cs), .carry(ccy), .cout(cco));

   // standalone counter row
   localparam int RN = 6;
   logic [RN-1:0] ra, rb, rc, rd, rs, rcy;
   logic          rco;
   c42_row #(.N(RN)) u_row (.a(ra), .b(rb), .c(rc), .d(rd),
                            .sum(rs), .carry(rcy), .cout(rco));

   int exp_q[$];

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int cout_at0 [16];
      rst = 1'b1;
      ma = '0; mb = '0; qa = '0; qb = '0;
      {ca, cb, cc, cd, cci} = '0;
      ra = '0; rb = '0; rc = '0; rd = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // starting state: zero operands, zero products (R5)
      @(negedge clk);
      chk("R5 initial product", int'(prod_p), 0);
      chk("R7 initial ripple product", int'(prod_r), 0);

      // R9: a change lands without any clock edge
      #0.5 ma = 8'd13; mb = 8'd11;
      #0.5 chk("R9 settles between edges", int'(prod_p), 143);

      // exhaustive 8x8 sweep with the reference model
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            @(posedge clk);
            ma = 8'(a); mb = 8'(b);
            exp_q.push_back(a * b);
            @(negedge clk);
            begin
               int e;
               e = exp_q.pop_front();
               chk("R1 prefix product", int'(prod_p), e);
               chk("R7 ripple product", int'(prod_r), e);
               if (a == 0 || b == 0)
                  chk("R5 zero operand", int'(prod_p), 0);
               if (a == 255 && b == 255) begin
                  chk("R5 full scale", int'(prod_p), 32'hFE01);
                  chk("R6 top column exact", int'(prod_r), 32'hFE01);
               end
            end
         end
      end

      // exhaustive 4x4 sweep (R8)
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            @(posedge clk);
            qa = 4'(a); qb = 4'(b);
            exp_q.push_back(a * b);
            @(negedge clk);
            chk("R8 4x4 product", int'(prod4), exp_q.pop_front());
         end
      end

      // counter cell truth table: bit 4 of v is cin, so cin=0 comes first
      for (int v = 0; v < 32; v++) begin
         @(posedge clk);
         {cci, cd, cc, cb, ca} = 5'(v);
         @(negedge clk);
         chk("R2 cell identity", int'(cs) + 2 * (int'(ccy) + int'(cco)),
             $countones(5'(v)));
         if (v < 16) cout_at0[v] = int'(cco);
         else chk("R3 cout ignores cin", int'(cco), cout_at0[v-16]);
      end

      // counter row: special words, then scrambled ones (R4)
      for (int t = 0; t < 400; t++) begin
         @(posedge clk);
         case (t)
            0: begin ra = '0;     rb = '0;     rc = '0;     rd = '0;     end
            1: begin ra = '1;     rb = '1;     rc = '1;     rd = '1;     end
            2: begin ra = 6'h15;  rb = 6'h2A;  rc = 6'h15;  rd = 6'h2A;  end
            3: begin ra = 6'h2A;  rb = 6'h2A;  rc = 6'h2A;  rd = 6'h01;  end
            default: begin
               ra = 6'((t * 37 + 5) % 64);
               rb = 6'((t * 53 + 11) % 64);
               rc = 6'((t * t + 7) % 64);
               rd = 6'((t * 29 + t / 3) % 64);
            end
         endcase
         exp_q.push_back(int'(ra) + int'(rb) + int'(rc) + int'(rd));
         @(negedge clk);
         chk("R4 row identity",
             int'(rs) + 2 * int'(rcy) + (1 << RN) * int'(rco),
             exp_q.pop_front());
      end

      finish_run();
   end
endmodule